// File: doc/BRIEF.md
# Controller Packet Decoder with Switch-Change Events

This block sits behind a track data receiver. Each cycle the receiver may hand it one packet: a 16-bit word and the number of bits that were received. The bit count alone tells the block what kind of packet it has. Packets of fewer than five bits are thrown away. A 13-bit packet is the synchronisation packet and restarts the packet slot counter at one. Every other accepted packet advances that counter by one. A 10-bit packet is a controller packet. It carries a car number, a 4-bit speed and a one-bit switch request. These are written into a table that holds one entry for each of up to six cars.

For every car the block remembers the switch value it last reported. A scanner walks over the cars in a circle. When it finds a car whose stored switch bit differs from the value last reported for that car, it offers an event on a valid/ready output. The event gives the car number and the new switch value. The reported value is updated only when the event is accepted.

The scanner has two named states:
- `SCAN_ST` looks at one car per cycle. On a mismatch it latches the car number and switch value and takes the *found* transition to `OFFER_ST`. Otherwise it takes the *advance* transition, stays in `SCAN_ST` and moves to the next car.
- `OFFER_ST` drives the event. On `evt_ready` it takes the *accept* transition back to `SCAN_ST`, starting at the car after the one just reported. While ready is low it takes the *hold* transition and stays in `OFFER_ST`.

Any car's speed and switch entry can be read combinationally through a car-index input.

Top module: `pktdec_top`

## Requirements
- R1: After reset, every speed and switch entry reads 0, `slot_count` is 0 and `evt_valid` is 0.
- R2: A packet with `pkt_len` below 5 changes neither the table nor `slot_count`.
- R3: A packet with `pkt_len` equal to 13 sets `slot_count` to 1 on the next clock edge.
- R4: Any other packet with `pkt_len` of 5 or more increments `slot_count` by one, wrapping modulo 256.
- R5: A packet with `pkt_len` equal to 10 is a controller packet. The car number is in `pkt_data[8:6]`, the speed in `pkt_data[4:1]` and the switch request in `pkt_data[5]`. The speed and switch request are stored for that car and can be read through `rd_car` after the edge that captures the packet.
- R6: A controller packet whose car number is 6 or 7 leaves the table unchanged.
- R7: An accepted packet whose length is not 10 leaves the table unchanged.
- R8: Each change of a car's stored switch bit away from its last reported value produces exactly one event carrying that car and the new value. A packet that writes the same switch value again produces no event.
- R9: While `evt_valid` is high and `evt_ready` is low, `evt_car` and `evt_switch` stay constant and `evt_valid` stays high.
- R10: After an accepted event for car c, scanning resumes at car c+1, wrapping from 5 to 0. Several pending changes are therefore reported in ascending cyclic car order, and `evt_valid` is low in the cycle after an accept.
- R11: Reading with `rd_car` of 6 or 7 returns speed 0 and switch 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_len | input | 6 | Number of bits received in the packet |
| pkt_data | input | 16 | Received packet bits |
| evt_valid | output | 1 | An event is offered |
| evt_ready | input | 1 | The consumer accepts the offered event |
| evt_car | output | 3 | Car number of the event |
| evt_switch | output | 1 | New switch value of the event |
| rd_car | input | 3 | Car index for the table read |
| rd_speed | output | 4 | Stored speed of the selected car |
| rd_switch | output | 1 | Stored switch request of the selected car |
| slot_count | output | 8 | Packet slot counter |

## Verification
The assertions assume the following about the inputs:
- The reset is asynchronous.
- The receiver presents at most one packet per cycle, and its fields are meaningful only while `pkt_valid` is high.
- The event consumer may hold `evt_ready` low for any length of time.

The stimulus keeps within these assumptions:
- The bench drives `pkt_valid` for exactly one cycle per packet and changes inputs only on the falling clock edge.
- It keeps `evt_ready` low while packets arrive, then raises it for a drain window long enough for a full scan of all cars.
- It sweeps every car code, including the two illegal ones, every speed and both switch values, and every length from 0 to 63.
- It runs more than 256 consecutive accepted packets so that the slot counter wraps.

// File: rtl/pktdec_pkg.sv
package pktdec_pkg;
    typedef enum logic [0:0] {
        SCAN_ST  = 1'b0,
        OFFER_ST = 1'b1
    } scan_state_e;
endpackage

// File: rtl/pktdec_classify.sv
module pktdec_classify #(
    parameter int LEN_W    = 6,
    parameter int DATA_W   = 16,
    parameter int NCARS    = 6,
    parameter int CAR_W    = 3,
    parameter int CAR_LSB  = 6,
    parameter int SW_POS   = 5,
    parameter int SPD_LSB  = 1,
    parameter int SPD_W    = 4,
    parameter int MIN_LEN  = 5,
    parameter int SYNC_LEN = 13,
    parameter int CTRL_LEN = 10
) (
    input  logic              in_valid,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [DATA_W-1:0] in_data,
    output logic              slot_load,
    output logic              slot_step,
    output logic              tbl_we,
    output logic [CAR_W-1:0]  tbl_car,
    output logic [SPD_W-1:0]  tbl_speed,
    output logic              tbl_sw
);
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] SYNC_L = LEN_W'(SYNC_LEN);
    localparam logic [LEN_W-1:0] CTRL_L = LEN_W'(CTRL_LEN);
    localparam logic [CAR_W-1:0] NCAR_C = CAR_W'(NCARS);
    localparam int               TOP_LO = CAR_LSB + CAR_W;

    logic accept;
    logic unused_data;

    assign unused_data = ^{in_data[DATA_W-1:TOP_LO], in_data[SPD_LSB-1:0]};

    always_comb begin
        accept    = in_valid && (in_len >= MIN_L);
        slot_load = accept && (in_len == SYNC_L);
        slot_step = accept && (in_len != SYNC_L);
        tbl_car   = in_data[CAR_LSB +: CAR_W];
        tbl_speed = in_data[SPD_LSB +: SPD_W];
        tbl_sw    = in_data[SW_POS];
        tbl_we    = accept && (in_len == CTRL_L) && (tbl_car < NCAR_C);
    end
endmodule

// File: rtl/pktdec_table.sv
module pktdec_table #(
    parameter int NCARS = 6,
    parameter int CAR_W = 3,
    parameter int SPD_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [CAR_W-1:0]       wr_car,
    input  logic [SPD_W-1:0]       wr_speed,
    input  logic                   wr_sw,
    output logic [NCARS-1:0]       sw_vec,
    output logic [NCARS*SPD_W-1:0] speed_flat
);
    for (genvar g = 0; g < NCARS; g++) begin : g_car
        localparam logic [CAR_W-1:0] ME = CAR_W'(g);
        logic [SPD_W-1:0] spd_q;
        logic             sw_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                spd_q <= '0;
                sw_q  <= 1'b0;
            end else if (we && (wr_car == ME)) begin
                spd_q <= wr_speed;
                sw_q  <= wr_sw;
            end
        end

        assign sw_vec[g]                    = sw_q;
        assign speed_flat[g*SPD_W +: SPD_W] = spd_q;
    end

    // R2
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(sw_vec) && $stable(speed_flat)));
endmodule

// File: rtl/pktdec_scan.sv
module pktdec_scan
    import pktdec_pkg::*;
#(
    parameter int NCARS = 6,
    parameter int CAR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCARS-1:0] sw_vec,
    input  logic             evt_ready,
    output logic             evt_valid,
    output logic [CAR_W-1:0] evt_car,
    output logic             evt_switch
);
    localparam logic [CAR_W-1:0] LAST_C = CAR_W'(NCARS - 1);
    localparam logic [CAR_W-1:0] NCAR_C = CAR_W'(NCARS);

    scan_state_e      state_q, state_d;
    logic [CAR_W-1:0] idx_q, idx_d;
    logic [CAR_W-1:0] car_q, car_d;
    logic             val_q, val_d;
    logic [NCARS-1:0] rep_q, rep_d;

    function automatic logic [CAR_W-1:0] step_car(input logic [CAR_W-1:0] c);
        return (c == LAST_C) ? '0 : c + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_ST;
            idx_q   <= '0;
            car_q   <= '0;
            val_q   <= 1'b0;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            car_q   <= car_d;
            val_q   <= val_d;
            rep_q   <= rep_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        car_d   = car_q;
        val_d   = val_q;
        rep_d   = rep_q;
        unique case (state_q)
            SCAN_ST: begin
                if (sw_vec[idx_q] != rep_q[idx_q]) begin
                    state_d = OFFER_ST;
                    car_d   = idx_q;
                    val_d   = sw_vec[idx_q];
                end else begin
                    idx_d = step_car(idx_q);
                end
            end
            OFFER_ST: begin
                if (evt_ready) begin
                    rep_d[car_q] = val_q;
                    state_d      = SCAN_ST;
                    idx_d        = step_car(car_q);
                end
            end
            default: state_d = SCAN_ST;
        endcase
    end

    always_comb begin
        evt_valid  = (state_q == OFFER_ST);
        evt_car    = car_q;
        evt_switch = val_q;
    end

    // R9
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_car) && $stable(evt_switch)));
    // R10
    evt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> !evt_valid);
    // R8
    evt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ((evt_car < NCAR_C) && (evt_switch != rep_q[evt_car])));
endmodule

// File: rtl/pktdec_top.sv
module pktdec_top #(
    parameter int LEN_W    = 6,
    parameter int DATA_W   = 16,
    parameter int NCARS    = 6,
    parameter int SPD_W    = 4,
    parameter int SLOT_W   = 8,
    parameter int MIN_LEN  = 5,
    parameter int SYNC_LEN = 13,
    parameter int CTRL_LEN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [2:0]        evt_car,
    output logic              evt_switch,
    input  logic [2:0]        rd_car,
    output logic [SPD_W-1:0]  rd_speed,
    output logic              rd_switch,
    output logic [SLOT_W-1:0] slot_count
);
    localparam int               CAR_W  = 3;
    localparam logic [CAR_W-1:0] NCAR_C = CAR_W'(NCARS);
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] SYNC_L = LEN_W'(SYNC_LEN);

    logic                   slot_load, slot_step, tbl_we, tbl_sw;
    logic [CAR_W-1:0]       tbl_car;
    logic [SPD_W-1:0]       tbl_speed;
    logic [NCARS-1:0]       sw_vec;
    logic [NCARS*SPD_W-1:0] speed_flat;
    logic [SLOT_W-1:0]      slot_q;

    pktdec_classify #(
        .LEN_W(LEN_W), .DATA_W(DATA_W), .NCARS(NCARS), .CAR_W(CAR_W),
        .CAR_LSB(6), .SW_POS(5), .SPD_LSB(1), .SPD_W(SPD_W),
        .MIN_LEN(MIN_LEN), .SYNC_LEN(SYNC_LEN), .CTRL_LEN(CTRL_LEN)
    ) u_cls (
        .in_valid(pkt_valid), .in_len(pkt_len), .in_data(pkt_data),
        .slot_load(slot_load), .slot_step(slot_step), .tbl_we(tbl_we),
        .tbl_car(tbl_car), .tbl_speed(tbl_speed), .tbl_sw(tbl_sw)
    );

    pktdec_table #(.NCARS(NCARS), .CAR_W(CAR_W), .SPD_W(SPD_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .wr_car(tbl_car),
        .wr_speed(tbl_speed), .wr_sw(tbl_sw),
        .sw_vec(sw_vec), .speed_flat(speed_flat)
    );

    pktdec_scan #(.NCARS(NCARS), .CAR_W(CAR_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .sw_vec(sw_vec), .evt_ready(evt_ready),
        .evt_valid(evt_valid), .evt_car(evt_car), .evt_switch(evt_switch)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         slot_q <= '0;
        else if (slot_load) slot_q <= SLOT_W'(1);
        else if (slot_step) slot_q <= slot_q + 1'b1;
    end

    assign slot_count = slot_q;

    always_comb begin
        if (rd_car < NCAR_C) begin
            rd_speed  = speed_flat[rd_car*SPD_W +: SPD_W];
            rd_switch = sw_vec[rd_car];
        end else begin
            rd_speed  = '0;
            rd_switch = 1'b0;
        end
    end

    // R3
    sync_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (pkt_len == SYNC_L)) |=> (slot_count == SLOT_W'(1)));
    // R2
    short_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid || (pkt_len < MIN_L)) |=> $stable(slot_count));
    // R4
    step_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (pkt_len >= MIN_L) && (pkt_len != SYNC_L))
            |=> (slot_count == $past(slot_count) + 1'b1));
endmodule

// File: tb/tb_pktdec_top.sv
module tb_pktdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [5:0]  pkt_len = '0;
    logic [15:0] pkt_data = '0;
    logic        evt_valid, evt_switch;
    logic        evt_ready = 1'b0;
    logic [2:0]  evt_car;
    logic [2:0]  rd_car = '0;
    logic [3:0]  rd_speed;
    logic        rd_switch;
    logic [7:0]  slot_count;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] m_spd [6];
    logic       m_sw  [6];
    logic       m_rep [6];
    logic [7:0] m_slot;

    int   ev_n;
    int   ev_car [16];
    logic ev_val [16];

    pktdec_top dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_data(pkt_data), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_car(evt_car), .evt_switch(evt_switch), .rd_car(rd_car),
        .rd_speed(rd_speed), .rd_switch(rd_switch), .slot_count(slot_count)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int car, input int spd, input int sw);
        return {7'b0, 3'(car), 1'(sw), 4'(spd), 1'b0};
    endfunction

    task automatic send(input int len, input logic [15:0] d);
        pkt_valid = 1'b1;
        pkt_len   = 6'(len);
        pkt_data  = d;
        @(negedge clk);
        pkt_valid = 1'b0;
        if (len >= 5) begin
            if (len == 13) m_slot = 8'd1;
            else           m_slot = m_slot + 8'd1;
        end
        if (len == 10 && d[8:6] < 3'd6) begin
            m_spd[d[8:6]] = d[4:1];
            m_sw[d[8:6]]  = d[5];
        end
    endtask

    task automatic chk_table(input string req);
        for (int c = 0; c < 6; c++) begin
            rd_car = 3'(c);
            #1;
            chk(rd_speed == m_spd[c], req, rd_speed, m_spd[c]);
            chk(rd_switch == m_sw[c], req, rd_switch, m_sw[c]);
        end
        for (int c = 6; c < 8; c++) begin
            rd_car = 3'(c);
            #1;
            // R11
            chk(rd_speed == 4'd0 && rd_switch == 1'b0, "R11", rd_speed, 0);
        end
        @(negedge clk);
    endtask

    task automatic collect(input int cyc);
        ev_n = 0;
        evt_ready = 1'b1;
        repeat (cyc) begin
            if (evt_valid && ev_n < 16) begin
                ev_car[ev_n] = evt_car;
                ev_val[ev_n] = evt_switch;
                ev_n++;
            end
            @(negedge clk);
        end
        evt_ready = 1'b0;
    endtask

    // drain and compare against the model's pending changes (R8)
    task automatic drain_and_check(input string req);
        int exp_n;
        exp_n = 0;
        for (int c = 0; c < 6; c++) if (m_sw[c] != m_rep[c]) exp_n++;
        collect(24);
        chk(ev_n == exp_n, req, ev_n, exp_n);
        for (int i = 0; i < ev_n; i++) begin
            chk(ev_car[i] < 6, req, ev_car[i], 0);
            if (ev_car[i] < 6) begin
                chk(m_sw[ev_car[i]] != m_rep[ev_car[i]], req, ev_car[i], -1);
                chk(ev_val[i] == m_sw[ev_car[i]], req, ev_val[i], m_sw[ev_car[i]]);
                m_rep[ev_car[i]] = ev_val[i];
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int desc;
        logic [15:0] d0;
        for (int c = 0; c < 6; c++) begin
            m_spd[c] = '0; m_sw[c] = 1'b0; m_rep[c] = 1'b0;
        end
        m_slot = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(evt_valid == 1'b0, "R1", evt_valid, 0);
        chk(slot_count == 8'd0, "R1", slot_count, 0);
        chk_table("R1");

        // R5 R6 R8: sweep car codes, speeds, switch values
        for (int car = 0; car < 8; car++)
            for (int spd = 0; spd < 16; spd++)
                for (int sw = 0; sw < 2; sw++) begin
                    send(10, mk(car, spd, sw ^ (spd & 1)));
                    chk(slot_count == m_slot, "R4", slot_count, m_slot);
                    chk_table(car < 6 ? "R5" : "R6");
                    drain_and_check("R8");
                end

        // R2 R3 R4 R7: sweep lengths
        for (int len = 0; len < 64; len++) begin
            send(len, mk(2, len & 15, m_sw[2] ? 0 : 1));
            chk(slot_count == m_slot, len < 5 ? "R2" : (len == 13 ? "R3" : "R4"),
                slot_count, m_slot);
            chk_table(len == 10 ? "R5" : (len < 5 ? "R2" : "R7"));
            drain_and_check("R8");
        end

        // R4 wrap of the slot counter
        send(13, 16'h0);
        for (int i = 0; i < 260; i++) send(6, 16'hFFFF);
        chk(slot_count == m_slot, "R4", slot_count, m_slot);
        chk(slot_count == 8'd5, "R4", slot_count, 5);

        // R9 hold with ready low
        send(10, mk(4, 7, m_sw[4] ? 0 : 1));
        send(10, mk(1, 3, m_sw[1] ? 0 : 1));
        repeat (12) @(negedge clk);
        chk(evt_valid == 1'b1, "R9", evt_valid, 1);
        begin
            int hc;
            logic hv;
            hc = evt_car;
            hv = evt_switch;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                chk(evt_valid && evt_car == 3'(hc) && evt_switch == hv, "R9", evt_car, hc);
            end
        end
        drain_and_check("R8");

        // R10 ordering of several pending changes
        for (int c = 0; c < 6; c += 2) send(10, mk(c, c, m_sw[c] ? 0 : 1));
        send(10, mk(5, 9, m_sw[5] ? 0 : 1));
        d0 = '0;
        collect(30);
        chk(ev_n == 4, "R10", ev_n, 4);
        desc = 0;
        for (int i = 0; i < ev_n; i++)
            if (ev_car[(i + 1) % ev_n] <= ev_car[i]) desc++;
        chk(desc == 1, "R10", desc, 1);
        for (int i = 0; i < ev_n; i++)
            if (ev_car[i] < 6) m_rep[ev_car[i]] = ev_val[i];

        // R8 rewrite of same switch value gives no event
        send(10, mk(3, 1, m_sw[3]));
        drain_and_check("R8");
        chk(ev_n == 0, "R8", ev_n, 0);
        chk_table("R5");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule